// File: doc/BRIEF.md
# Latching Multi-Row Wordline Activator

This block holds one set-only latch per local wordline so that several rows of a memory array can be opened together. A controller first issues a clear command, which empties every latch and arms the block. It then streams row addresses, one beat per cycle, in any order. Each accepted address sets its row's latch, and the latch stays set until the next clear. Rows therefore accumulate across beats. When the drive control is raised, every latched row is driven at once. When it is lowered, the wordlines fall, but the latches keep their contents.

The address stream is a valid/ready interface. `addr_ready` is high only while the block is armed and no clear is being issued in the same cycle. The block never stalls a beat. A beat offered while `addr_ready` is low is consumed: it has no effect and is reported as a fault. An accepted beat can still be refused for either of two reasons. Its address may lie outside the row range. Or it may name a new row while the number of open rows has already reached the configured limit, which is 2 for a low on/off-ratio cell and up to 128 for a high-ratio cell. A refused beat raises the fault flag for one cycle together with a cause code. Repeating an address that is already open is harmless. `open_count` reports how many latches are set, for use by the sense stage.

Top module: `mrw_activator`

## Requirements
- R1: While `rst_n` is low and after it is released, `wl` is all zero, `open_count` is 0, `addr_ready` is 0, `err` is 0 and `err_code` is 0 (none).
- R2: A cycle with `clr_cmd` high clears every latch and `open_count` on the next edge and arms the block. `addr_ready` equals armed AND NOT `clr_cmd`, and it stays low until the first clear.
- R3: A beat with `addr_valid` and `addr_ready` high, an address below NUM_ROWS that is not yet latched, and `open_count` below MAX_OPEN, sets that row's latch and increments `open_count` at the next edge. A set latch stays set until a clear.
- R4: A beat with `addr_valid` high while `addr_ready` is low changes no latch and no count. In the next cycle it gives `err`=1 and `err_code`=1 (not ready).
- R5: An accepted beat that names a new row while `open_count` equals MAX_OPEN is ignored. It gives `err`=1 and `err_code`=2 (limit) in the next cycle.
- R6: An accepted beat that names an already-latched row leaves the latches and `open_count` unchanged and raises no fault, even at the limit.
- R7: An accepted beat with an address at or above NUM_ROWS is ignored. It gives `err`=1 and `err_code`=3 (range). Not-ready takes precedence over range, and range takes precedence over limit.
- R8: `wl` equals the latch vector in the same cycle that `act_en` is high and is zero while `act_en` is low. `act_en` never alters the latches.
- R9: `open_count` always equals the number of set latches and never exceeds MAX_OPEN.
- R10: `err_code` is 0 and `err` is 0 in any cycle that follows a cycle without a faulting beat. Each faulting beat flags exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; disarms the block |
| clr_cmd | input | 1 | Clear all latches and arm |
| act_en | input | 1 | Drive latched rows onto the wordlines |
| addr_valid | input | 1 | Address beat present |
| addr | input | ADDR_W | Row address of the beat |
| addr_ready | output | 1 | Block will take the beat this cycle |
| wl | output | NUM_ROWS | Wordline vector, one bit per row |
| open_count | output | $clog2(MAX_OPEN+1) | Number of latched rows |
| err | output | 1 | Fault flag for the previous cycle's beat |
| err_code | output | 2 | Fault cause: 0 none, 1 not ready, 2 limit, 3 range |

## Verification
The bench builds the block with NUM_ROWS=12, MAX_OPEN=4 and ADDR_W=4. With these values, addresses 12 to 15 reach the range fault. The four-row limit is reached within a handful of beats, so refusals at the limit and repeats at the limit occur often under random traffic. The row count is small enough that random sequences revisit rows often, which exercises the repeat-address path. Row 11 is used as the upper boundary, and clears issued together with a valid beat check how not-ready interacts with the arming rule.

// File: rtl/mrw_pkg.sv
package mrw_pkg;
  typedef enum logic [1:0] {
    FLT_NONE     = 2'd0,
    FLT_NOTREADY = 2'd1,
    FLT_LIMIT    = 2'd2,
    FLT_RANGE    = 2'd3
  } fault_e;
endpackage

// File: rtl/mrw_arm_ctrl.sv
module mrw_arm_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_cmd,
  output logic armed
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       armed <= 1'b0;
    else if (clr_cmd) armed <= 1'b1;
  end

  // R2: once armed, stays armed until power reset
  assert_arm_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed);
endmodule

// File: rtl/mrw_admit.sv
module mrw_admit
  import mrw_pkg::*;
#(
  parameter int NUM_ROWS = 48,
  parameter int ADDR_W   = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                addr_valid,
  input  logic                ready,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NUM_ROWS-1:0] row_set,
  input  logic                full,
  output logic [NUM_ROWS-1:0] set_vec,
  output fault_e              code_q
);
  logic [NUM_ROWS-1:0] dec;
  logic in_range, already, take;
  fault_e code_d;

  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_dec
    assign dec[i] = (addr == ADDR_W'(i));
  end

  assign in_range = |dec;
  assign already  = |(dec & row_set);
  assign take     = addr_valid && ready && in_range && !already && !full;
  assign set_vec  = dec & {NUM_ROWS{take}};

  always_comb begin
    code_d = FLT_NONE;
    if (addr_valid) begin
      if (!ready)                 code_d = FLT_NOTREADY;
      else if (!in_range)         code_d = FLT_RANGE;
      else if (!already && full)  code_d = FLT_LIMIT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= FLT_NONE;
    else        code_q <= code_d;
  end

  // R4: a beat offered while not ready is flagged next cycle
  assert_notready_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && !ready) |=> (code_q == FLT_NOTREADY));
  // R10: no beat, no fault
  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_valid |=> (code_q == FLT_NONE));
  // R3: at most one row set per beat
  assert_single_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_vec));
endmodule

// File: rtl/mrw_latch_bank.sv
module mrw_latch_bank #(
  parameter int NUM_ROWS = 48
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic [NUM_ROWS-1:0] set_vec,
  output logic [NUM_ROWS-1:0] lat
);
  for (genvar i = 0; i < NUM_ROWS; i++) begin : g_row
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          lat[i] <= 1'b0;
      else if (clr)        lat[i] <= 1'b0;
      else if (set_vec[i]) lat[i] <= 1'b1;
    end
  end

  // R2: clear empties the bank
  assert_clear_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (lat == '0));
  // R3: latched rows hold until a clear
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (($past(lat) & ~lat) == '0));
endmodule

// File: rtl/mrw_open_counter.sv
module mrw_open_counter #(
  parameter int MAX_OPEN = 8,
  parameter int CNT_W    = $clog2(MAX_OPEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  assign full = (count >= CNT_W'(MAX_OPEN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= count + 1'b1;
  end

  // R9: count is capped at the limit
  assert_count_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(MAX_OPEN));
  // R5: a full counter never grows
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !clr) |=> (count == $past(count)));
endmodule

// File: rtl/mrw_activator.sv
module mrw_activator
  import mrw_pkg::*;
#(
  parameter int NUM_ROWS = 48,
  parameter int MAX_OPEN = 8,
  parameter int ADDR_W   = 6
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             clr_cmd,
  input  logic                             act_en,
  input  logic                             addr_valid,
  input  logic [ADDR_W-1:0]                addr,
  output logic                             addr_ready,
  output logic [NUM_ROWS-1:0]              wl,
  output logic [$clog2(MAX_OPEN+1)-1:0]    open_count,
  output logic                             err,
  output logic [1:0]                       err_code
);
  localparam int CNT_W = $clog2(MAX_OPEN + 1);

  logic                armed, full;
  logic [NUM_ROWS-1:0] lat, set_vec;
  fault_e              code_q;

  mrw_arm_ctrl u_arm (
    .clk(clk), .rst_n(rst_n), .clr_cmd(clr_cmd), .armed(armed)
  );

  assign addr_ready = armed && !clr_cmd;

  mrw_admit #(.NUM_ROWS(NUM_ROWS), .ADDR_W(ADDR_W)) u_admit (
    .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .ready(addr_ready),
    .addr(addr), .row_set(lat), .full(full), .set_vec(set_vec), .code_q(code_q)
  );

  mrw_latch_bank #(.NUM_ROWS(NUM_ROWS)) u_bank (
    .clk(clk), .rst_n(rst_n), .clr(clr_cmd), .set_vec(set_vec), .lat(lat)
  );

  mrw_open_counter #(.MAX_OPEN(MAX_OPEN), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(clr_cmd), .inc(|set_vec),
    .count(open_count), .full(full)
  );

  assign wl       = act_en ? lat : '0;
  assign err_code = code_q;
  assign err      = (code_q != FLT_NONE);

  // R9: counter and latch bank agree
  assert_count_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lat) == int'(open_count));
  // R2: nothing latches before the first clear
  assert_unarmed_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (lat == '0));
endmodule

// File: tb/sim_mrw_activator.sv
`timescale 1ns/1ps
module sim_mrw_activator;
  localparam int NR = 12;
  localparam int MO = 4;
  localparam int AW = 4;
  localparam int CW = $clog2(MO + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic clr_cmd = 0, act_en = 0, addr_valid = 0;
  logic [AW-1:0] addr = '0;
  logic addr_ready, err;
  logic [NR-1:0] wl;
  logic [CW-1:0] open_count;
  logic [1:0] err_code;

  int total = 0, bad = 0;
  bit done = 0;

  logic [NR-1:0] m_lat = '0;
  int  m_cnt = 0;
  bit  m_armed = 0;
  logic [1:0] m_code = 2'd0;

  always #5 clk = ~clk;

  mrw_activator #(.NUM_ROWS(NR), .MAX_OPEN(MO), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .clr_cmd(clr_cmd), .act_en(act_en),
    .addr_valid(addr_valid), .addr(addr), .addr_ready(addr_ready), .wl(wl),
    .open_count(open_count), .err(err), .err_code(err_code)
  );

  function automatic logic [1:0] fault_of(bit v, bit rdy, int a);
    if (!v) return 2'd0;
    if (!rdy) return 2'd1;
    if (a >= NR) return 2'd3;
    if (!m_lat[a] && m_cnt >= MO) return 2'd2;
    return 2'd0;
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "wl", int'(wl), act_en ? int'(m_lat) : 0);
    chk(tag, "open_count", int'(open_count), m_cnt);
    chk(tag, "err_code", int'(err_code), int'(m_code));
    chk(tag, "err", int'(err), int'(m_code != 2'd0));
    chk(tag, "addr_ready", int'(addr_ready), int'(m_armed && !clr_cmd));
  endtask

  // drive at negedge, model the edge, check at the next negedge
  task automatic cyc(bit c, bit v, int a, bit act, string tag);
    bit rdy;
    clr_cmd = c; addr_valid = v; addr = AW'(a); act_en = act;
    rdy = m_armed && !c;
    @(posedge clk);
    m_code = fault_of(v, rdy, a);
    if (c) begin
      m_lat = '0; m_cnt = 0; m_armed = 1;
    end else if (v && rdy && a < NR && !m_lat[a] && m_cnt < MO) begin
      m_lat[a] = 1'b1; m_cnt++;
    end
    @(negedge clk);
    check_all(tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check_all("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");
    cyc(0, 1, 3, 1, "R4");           // before any clear
    cyc(0, 0, 0, 1, "R10");
    cyc(1, 0, 0, 0, "R2");
    cyc(0, 1, 5, 0, "R3");
    cyc(0, 1, 0, 0, "R3");
    cyc(0, 1, 11, 0, "R3");          // top row
    cyc(0, 0, 0, 1, "R8");
    cyc(0, 0, 0, 0, "R8");
    cyc(0, 1, 5, 1, "R6");
    cyc(0, 1, 12, 1, "R7");
    cyc(0, 1, 15, 1, "R7");
    cyc(0, 1, 7, 1, "R3");
    cyc(0, 1, 9, 1, "R5");           // limit reached
    cyc(0, 1, 14, 1, "R7");          // range wins over limit
    cyc(0, 1, 7, 1, "R6");           // repeat at limit
    cyc(1, 1, 2, 1, "R4");           // clear with beat: not ready
    cyc(0, 1, 2, 1, "R2");
    for (int i = 0; i < 3000; i++) begin
      bit c = ($urandom % 16) == 0;
      bit v = ($urandom % 4) != 0;
      int a = $urandom % 16;
      bit act = $urandom % 2;
      cyc(c, v, a, act, "R9");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule